// File: doc/BRIEF.md
# Multi-Width Serial SRAM Slave

This block is the target side of a serial SRAM. It sits behind a chip select, a serial clock and four bidirectional data lines, and it holds a byte-wide memory array whose size is set by a parameter. Each transaction starts when chip select falls. The engine first collects an 8-bit opcode. It then takes a 24-bit start address when the opcode is a memory access, and after that it streams data bytes. Every field is sent most-significant bit first. The engine also executes opcodes that change the bus width and opcodes that read or write an 8-bit mode register.

The bus width is persistent state. In single-bit mode, data enters on line 0 and leaves on line 1. In two-line mode, lines 1..0 carry two bits per clock. In four-line mode, lines 3..0 carry four bits per clock. In every mode the lowest-numbered line holds the least significant bit of each chunk. The opcode is shifted at the current width, so a host must track the mode it has set. The pad-level tri-state buffers sit outside the block and are driven from the per-line enable outputs.

SCK, chip select and the data lines are sampled with the system clock, and the engine reacts to their sampled edges. Input bits are taken on SCK rising edges. Output chunks are updated after SCK falling edges.

Top module: `sram_serial_slave`

## Requirements
- R1: After reset, and in every cycle after chip select has been seen high, all four output enables are 0. The engine is then waiting for an opcode.
- R2: In single-bit mode, opcode 02h writes and opcode 03h reads. Each is followed by a 24-bit address and then data. Input bits are taken from line 0 and read data leaves on line 1, MSB first.
- R3: The driven output value changes only after an SCK falling edge. It stays constant across the following rising edge.
- R4: During a read or a write burst, the address advances by one after each byte. It wraps from the top of the array to address 0 for as long as chip select stays low.
- R5: Opcode 3Bh selects two-line mode. Every later field moves two bits per SCK edge, on lines 1..0 with line 1 holding the higher bit. While read data is driven, the output enables are 0011b.
- R6: Opcode 38h selects four-line mode. Every later field moves four bits per edge, on lines 3..0 with line 3 holding the highest bit. While read data is driven, the output enables are 1111b.
- R7: The selected width persists across transactions. Only opcode FFh (sent at the current width) or reset returns the block to single-bit mode.
- R8: Opcode 01h writes the following byte into the 8-bit mode register. Opcode 05h returns that register repeatedly, once per byte slot. The register resets to 00h and is independent of the bus width.
- R9: Chip select going high in the middle of a byte throws the partial byte away: no memory cell changes. It also turns all output enables off, and the next transaction decodes a fresh opcode.
- R10: Any other opcode value is ignored for the rest of the transaction. No memory cell changes and no output is enabled.
- R11: Of the 24-bit address, only the low ADDR_W bits select a cell. The upper bits are ignored.
- R12: Output enables are nonzero only in a read-data or mode-register-read phase. During the opcode and address fields they stay 0. In single-bit mode they are 0010b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| sio_in | input | 4 | Sampled value of the four data pads |
| sio_out | output | 4 | Value to drive onto the four data pads |
| sio_oe | output | 4 | Per-line drive enable for the pad buffers |

## Verification
The bench runs full-array bursts in all three widths. Each burst starts near the top of a 16-byte array, so the address wrap is crossed. A design that failed to wrap or to increment would return bytes out of place, and a wrong line order in two- or four-line mode would return bit-permuted data. It sends a write with junk upper address bits, which would land in the wrong cell if those bits were decoded. Chip select is aborted mid-byte during a write and during a read: a design that committed a partial byte would corrupt a cell, and one that kept driving would leave an enable set. It also sends an undefined opcode followed by bytes that a careless decoder would store. It switches width back and forth across transactions and confirms that the mode register survives those switches.

// File: rtl/sss_pkg.sv
package sss_pkg;

  typedef enum logic [1:0] {
    BUS_X1 = 2'd0,
    BUS_X2 = 2'd1,
    BUS_X4 = 2'd2
  } bus_w_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WR,
    PH_RD,
    PH_MRW,
    PH_MRR,
    PH_SKIP
  } phase_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_QUAD  = 8'h38;
  localparam logic [7:0] OP_DUAL  = 8'h3B;
  localparam logic [7:0] OP_X1    = 8'hFF;
  localparam logic [7:0] OP_MR_RD = 8'h05;
  localparam logic [7:0] OP_MR_WR = 8'h01;

  localparam int ADDR_BYTES = 3;

  // bits moved per SCK edge
  function automatic logic [3:0] lanes(bus_w_e w);
    case (w)
      BUS_X1:  return 4'd1;
      BUS_X2:  return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  // append the sampled pins to a partial byte, MSB first
  function automatic logic [7:0] shift_in(logic [7:0] cur, logic [3:0] pins, bus_w_e w);
    case (w)
      BUS_X1:  return {cur[6:0], pins[0]};
      BUS_X2:  return {cur[5:0], pins[1:0]};
      default: return {cur[3:0], pins};
    endcase
  endfunction

  // chunk of a byte to place on the pads after 'sent' bits already left
  function automatic logic [3:0] chunk_out(logic [7:0] b, logic [2:0] sent, bus_w_e w);
    logic [7:0] t;
    t = b << sent;
    case (w)
      BUS_X1:  return {2'b00, t[7], 1'b0};
      BUS_X2:  return {2'b00, t[7:6]};
      default: return t[7:4];
    endcase
  endfunction

  function automatic logic [3:0] oe_mask(bus_w_e w);
    case (w)
      BUS_X1:  return 4'b0010;
      BUS_X2:  return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // true when the chunk at position cnt completes a byte
  function automatic logic last_chunk(logic [2:0] cnt, bus_w_e w);
    return ({1'b0, cnt} + lanes(w)) == 4'd8;
  endfunction

endpackage

// File: rtl/sss_pin_sync.sv
module sss_pin_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] sio_in,
  output logic       cs_act,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic [3:0] pins
);

  logic       sck_a;
  logic       sck_b;
  logic       cs_a;
  logic [3:0] pin_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_a <= 1'b0;
      sck_b <= 1'b0;
      cs_a  <= 1'b1;
      pin_a <= 4'h0;
    end else begin
      sck_a <= sck;
      sck_b <= sck_a;
      cs_a  <= cs_n;
      pin_a <= sio_in;
    end
  end

  assign cs_act   = ~cs_a;
  assign sck_rise = sck_a & ~sck_b & ~cs_a;
  assign sck_fall = ~sck_a & sck_b & ~cs_a;
  assign pins     = pin_a;

endmodule

// File: rtl/sss_rx_deser.sv
module sss_rx_deser
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       rise,
  input  bus_w_e     width,
  input  logic [3:0] pins,
  output logic       byte_done,
  output logic [7:0] byte_val
);

  logic [7:0] sh;
  logic [2:0] cnt;
  logic [3:0] step;

  assign step      = lanes(width);
  assign byte_val  = shift_in(sh, pins, width);
  assign byte_done = rise & last_chunk(cnt, width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= 8'h00;
      cnt <= 3'd0;
    end else if (!cs_act) begin
      sh  <= 8'h00;
      cnt <= 3'd0;
    end else if (rise) begin
      sh  <= byte_val;
      cnt <= cnt + step[2:0];
    end
  end

endmodule

// File: rtl/sss_tx_ser.sv
module sss_tx_ser
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       fall,
  input  logic       emit_en,
  input  bus_w_e     width,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic [7:0] next_byte,
  output logic [3:0] out,
  output logic [3:0] oe,
  output logic       byte_sent
);

  logic [7:0] cur;
  logic [2:0] cnt;
  logic [3:0] step;

  assign step      = lanes(width);
  assign byte_sent = fall & emit_en & last_chunk(cnt, width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= 8'h00;
      cnt <= 3'd0;
      out <= 4'h0;
      oe  <= 4'h0;
    end else if (!cs_act) begin
      cnt <= 3'd0;
      oe  <= 4'h0;
    end else if (load) begin
      cur <= load_byte;
      cnt <= 3'd0;
    end else if (fall && emit_en) begin
      out <= chunk_out(cur, cnt, width);
      oe  <= oe_mask(width);
      if (byte_sent) begin
        cur <= next_byte;
        cnt <= 3'd0;
      end else begin
        cnt <= cnt + step[2:0];
      end
    end
  end

endmodule

// File: rtl/sss_byte_ram.sv
module sss_byte_ram #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/sram_serial_slave.sv
module sram_serial_slave
  import sss_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe
);

  localparam int IDX_LAST = ADDR_BYTES - 1;

  logic              cs_act;
  logic              sck_rise;
  logic              sck_fall;
  logic [3:0]        pins;
  logic              byte_done;
  logic [7:0]        rx_byte;
  logic              tx_sent;

  bus_w_e            width;
  phase_e            phase;
  logic              op_rd;
  logic [1:0]        addr_idx;
  logic [ADDR_W-1:0] addr_acc;
  logic [ADDR_W-1:0] addr_ptr;
  logic [7:0]        mode_reg;

  // named events for the checker
  logic              cmd_done;
  logic              addr_done;
  logic              emit_en;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] raddr;
  logic [7:0]        rdata;
  logic              mem_we;
  logic              tx_load;
  logic [7:0]        tx_load_byte;
  logic [7:0]        tx_next_byte;

  sss_pin_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .sio_in   (sio_in),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .pins     (pins)
  );

  sss_rx_deser u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .rise      (sck_rise),
    .width     (width),
    .pins      (pins),
    .byte_done (byte_done),
    .byte_val  (rx_byte)
  );

  // keep only the low address bits as the bytes arrive
  function automatic logic [ADDR_W-1:0] fold_addr(logic [ADDR_W-1:0] acc, logic [7:0] b);
    return (acc << 8) | ADDR_W'(b);
  endfunction

  assign cmd_done   = byte_done && (phase == PH_CMD);
  assign addr_done  = byte_done && (phase == PH_ADDR) && (addr_idx == 2'(IDX_LAST));
  assign start_addr = fold_addr(addr_acc, rx_byte);
  assign emit_en    = (phase == PH_RD) || (phase == PH_MRR);
  assign mem_we     = byte_done && (phase == PH_WR);
  assign raddr      = addr_done ? start_addr : addr_ptr + ADDR_W'(1);

  assign tx_load      = (addr_done && op_rd) || (cmd_done && (rx_byte == OP_MR_RD));
  assign tx_load_byte = (phase == PH_CMD) ? mode_reg : rdata;
  assign tx_next_byte = (phase == PH_MRR) ? mode_reg : rdata;

  sss_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_ptr),
    .wdata (rx_byte),
    .raddr (raddr),
    .rdata (rdata)
  );

  sss_tx_ser u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .fall      (sck_fall),
    .emit_en   (emit_en),
    .width     (width),
    .load      (tx_load),
    .load_byte (tx_load_byte),
    .next_byte (tx_next_byte),
    .out       (sio_out),
    .oe        (sio_oe),
    .byte_sent (tx_sent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width    <= BUS_X1;
      phase    <= PH_CMD;
      op_rd    <= 1'b0;
      addr_idx <= 2'd0;
      addr_acc <= '0;
      addr_ptr <= '0;
      mode_reg <= 8'h00;
    end else if (!cs_act) begin
      phase    <= PH_CMD;
      addr_idx <= 2'd0;
    end else begin
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            addr_idx <= 2'd0;
            addr_acc <= '0;
            case (rx_byte)
              OP_READ:  begin phase <= PH_ADDR; op_rd <= 1'b1; end
              OP_WRITE: begin phase <= PH_ADDR; op_rd <= 1'b0; end
              OP_DUAL:  begin width <= BUS_X2; phase <= PH_SKIP; end
              OP_QUAD:  begin width <= BUS_X4; phase <= PH_SKIP; end
              OP_X1:    begin width <= BUS_X1; phase <= PH_SKIP; end
              OP_MR_RD: phase <= PH_MRR;
              OP_MR_WR: phase <= PH_MRW;
              default:  phase <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            addr_acc <= start_addr;
            addr_idx <= addr_idx + 2'd1;
            if (addr_idx == 2'(IDX_LAST)) begin
              addr_ptr <= start_addr;
              phase    <= op_rd ? PH_RD : PH_WR;
            end
          end
          PH_WR:   addr_ptr <= addr_ptr + ADDR_W'(1);
          PH_MRW:  mode_reg <= rx_byte;
          default: ;
        endcase
      end
      if (tx_sent && (phase == PH_RD)) addr_ptr <= addr_ptr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/sss_chk.sv
module sss_chk
  import sss_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sck_fall,
  input logic              cmd_done,
  input logic              addr_done,
  input logic              in_read,
  input bus_w_e            width,
  input logic [ADDR_W-1:0] addr_ptr,
  input logic [3:0]        sio_out,
  input logic [3:0]        sio_oe
);

  // R1
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (sio_oe == 4'h0));

  // R3
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_out != $past(sio_out)) |-> $past(sck_fall));

  // R12
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe != 4'h0) |-> in_read);

  // R5
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe != 4'h0) |-> (sio_oe == oe_mask(width)));

  // R7
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width != $past(width)) |-> $past(cmd_done));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ptr != $past(addr_ptr)) |->
      ($past(addr_done) || (addr_ptr == $past(addr_ptr) + ADDR_W'(1))));

endmodule

bind sram_serial_slave sss_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_act    (cs_act),
  .sck_fall  (sck_fall),
  .cmd_done  (cmd_done),
  .addr_done (addr_done),
  .in_read   (emit_en),
  .width     (width),
  .addr_ptr  (addr_ptr),
  .sio_out   (sio_out),
  .sio_oe    (sio_oe)
);

// File: tb/sram_serial_slave_test.sv
module sram_serial_slave_test;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] sio_in = 4'h0;
  logic [3:0] sio_out;
  logic [3:0] sio_oe;

  int nchk = 0;
  int nfail = 0;
  int bw = 1;
  logic [3:0] last_oe;
  logic [7:0] exp_mem [DEPTH];

  sram_serial_slave #(.ADDR_W(AW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sck     (sck),
    .sio_in  (sio_in),
    .sio_out (sio_out),
    .sio_oe  (sio_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mask_of(int w);
    return (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
  endfunction

  // one SCK period: drive, sample before rise, confirm no change across rise
  task automatic half(input logic [3:0] drv, output logic [3:0] got);
    @(negedge clk);
    sio_in = drv;
    repeat (6) @(negedge clk);
    got = sio_out;
    last_oe = sio_oe;
    sck = 1'b1;
    repeat (6) @(negedge clk);
    if (sio_oe != 4'h0) chk("R3 output held across rising edge", sio_out, got);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] s;
    s = tx;
    rx = 8'h00;
    for (int k = 0; k < 8 / bw; k++) begin
      logic [3:0] d;
      logic [3:0] g;
      case (bw)
        1:       d = {3'b000, s[7]};
        2:       d = {2'b00, s[7:6]};
        default: d = s[7:4];
      endcase
      half(d, g);
      case (bw)
        1:       rx = {rx[6:0], g[1]};
        2:       rx = {rx[5:0], g[1:0]};
        default: rx = {rx[3:0], g};
      endcase
      s = s << bw;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] dum;
    xfer(a[23:16], dum);
    xfer(a[15:8], dum);
    xfer(a[7:0], dum);
  endtask

  task automatic one_op(input logic [7:0] op);
    logic [7:0] dum;
    cs_lo();
    xfer(op, dum);
    cs_hi();
  endtask

  task automatic wr_burst(input logic [23:0] a, input int n, input int seed);
    logic [7:0] dum;
    cs_lo();
    xfer(8'h02, dum);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(seed * 29 + i * 53 + 7);
      xfer(d, dum);
      exp_mem[(int'(a[AW-1:0]) + i) % DEPTH] = d;
    end
    cs_hi();
  endtask

  task automatic rd_burst(input logic [23:0] a, input int n, input string tag);
    logic [7:0] got;
    cs_lo();
    xfer(8'h03, got);
    send_addr(a);
    chk("R12 no drive during address field", last_oe, 0);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, got);
      chk(tag, got, exp_mem[(int'(a[AW-1:0]) + i) % DEPTH]);
      chk("R12 enable shape in read data", last_oe, mask_of(bw));
    end
    cs_hi();
  endtask

  task automatic rd_mr(input logic [7:0] e, input string tag);
    logic [7:0] got;
    cs_lo();
    xfer(8'h05, got);
    xfer(8'h00, got);
    chk(tag, got, e);
    xfer(8'h00, got);
    chk(tag, got, e);
    cs_hi();
  endtask

  task automatic wr_mr(input logic [7:0] v);
    logic [7:0] dum;
    cs_lo();
    xfer(8'h01, dum);
    xfer(v, dum);
    cs_hi();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0] g;
    logic [7:0] dum;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 enables off after reset", sio_oe, 0);
    chk("R1 output idle after reset", sio_out, 0);

    // R8 reset value of the mode register
    rd_mr(8'h00, "R8 mode register reset value");

    // single-bit: write with junk upper address bits across the wrap
    bw = 1;
    wr_burst(24'hABCD0A, DEPTH, 1);   // R11 R4
    rd_burst(24'h000000, DEPTH, "R2 single-bit readback (R11 R4 placement)");
    rd_burst(24'h00000E, 4, "R4 read wraps at top");

    // R9 abort mid-byte during a write
    cs_lo();
    xfer(8'h02, dum);
    send_addr(24'h000003);
    for (int k = 0; k < 4; k++) half(4'h1, g);
    cs_hi();
    chk("R9 enables off after abort", sio_oe, 0);
    rd_burst(24'h000003, 1, "R9 partial byte discarded");

    // R9 abort mid-read
    cs_lo();
    xfer(8'h03, dum);
    send_addr(24'h000005);
    for (int k = 0; k < 3; k++) half(4'h0, g);
    chk("R12 single-bit read enable", last_oe, 4'b0010);
    cs_hi();
    chk("R1 enables off after chip select high", sio_oe, 0);

    // R10 undefined opcode followed by would-be data
    cs_lo();
    xfer(8'h5A, dum);
    for (int k = 0; k < 4; k++) begin
      xfer(8'hA5, dum);
      chk("R10 no drive after undefined opcode", last_oe, 0);
    end
    cs_hi();
    rd_burst(24'h000000, DEPTH, "R10 memory unchanged");

    // two-line mode
    one_op(8'h3B);
    bw = 2;
    wr_burst(24'h00000C, 6, 2);
    rd_burst(24'hFF0000, DEPTH, "R5 two-line readback");
    wr_mr(8'hC3);
    rd_mr(8'hC3, "R8 mode register in two-line mode");
    rd_burst(24'h000007, 3, "R7 two-line persists");

    // back to single-bit
    one_op(8'hFF);
    bw = 1;
    rd_burst(24'h000002, 5, "R7 return from two-line");

    // four-line mode
    one_op(8'h38);
    bw = 4;
    wr_burst(24'h00000D, 8, 3);
    rd_burst(24'h000000, DEPTH, "R6 four-line readback");
    rd_mr(8'hC3, "R8 mode register in four-line mode");

    one_op(8'hFF);
    bw = 1;
    rd_burst(24'h000000, DEPTH, "R7 return from four-line");
    rd_mr(8'hC3, "R8 mode register kept in single-bit");

    finish_run();
  end

endmodule